// File: doc/BRIEF.md
# Reduced RV32 Single-Cycle Core

This block is a single-cycle processor that runs a small integer subset of RV32I. It supports four register-register operations (add, subtract, and, or) and an add-immediate. It has a word load and a word store, two conditional branches (equal and not-equal), and two jumps that save a link address (PC-relative, and register-plus-offset). Each clock edge retires exactly one instruction. The program counter drives the fetch address, the fetched word is decoded in the same cycle, and the result is written back to the register file or to data memory on the next rising edge.

Instruction memory and data memory are outside the core. Both ports are plain combinational ports with no valid/ready handshake and no back-pressure. The memory must return the word for the presented address within the same cycle, and the data memory captures a store on the rising edge when the write enable is high. Any encoding outside the supported subset raises `illegal`. That instruction is then treated as a no-op that still advances the PC by 4.

Top module: `rvl_core`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high on a rising edge, the PC becomes 0, so `imem_addr` reads 0 in the cycle after any reset edge.
- R2: Every legal instruction that is not a branch or jump moves the PC to PC+4. Instructions execute in program order, one per cycle.
- R3: ADDI (opcode 0010011, funct3 000) writes rs1 plus the sign-extended 12-bit immediate from bits 31:20 into rd. The word 0x00500093 leaves 5 in x1.
- R4: Opcode 0110011 with funct7 0000000 selects ADD (funct3 000), OR (funct3 110) and AND (funct3 111). Funct7 0100000 with funct3 000 selects SUB. The result is written to rd.
- R5: LW (opcode 0000011, funct3 010) presents rs1 plus the I-immediate on `dmem_addr` with `dmem_we` low, and writes `dmem_rdata` into rd.
- R6: SW (opcode 0100011, funct3 010) drives `dmem_we` high, `dmem_addr` = rs1 + imm, and `dmem_wdata` = rs2. Its immediate has bits 11:5 taken from instruction bits 31:25 and bits 4:0 taken from bits 11:7.
- R7: Opcode 1100011 with funct3 000 (equal) or 001 (not equal) compares rs1 with rs2. When the condition holds, the PC moves to PC plus the B offset: {b31, b7, b30:25, b11:8, 0}, sign-extended. Otherwise the PC moves to PC+4. Forward and backward offsets both work.
- R8: JAL (opcode 1101111) writes PC+4 to rd and jumps to PC plus the J offset: {b31, b19:12, b20, b30:21, 0}, sign-extended.
- R9: JALR (opcode 1100111, funct3 000) writes PC+4 to rd and jumps to (rs1 + I-immediate) with bit 0 cleared. The target uses the value rs1 held before the write, even when rd equals rs1.
- R10: x0 always reads as zero, and any write addressed to it is discarded.
- R11: Any other encoding drives `illegal` high for that cycle. It writes no register, keeps `dmem_we` low, and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Fetch address (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Data memory byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, captured on the rising edge |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, same cycle |
| illegal | output | 1 | Current instruction is outside the supported subset |

## Verification
The bound checker watches four things on every cycle:
- The PC returns to zero after reset.
- The PC steps by 4 after plain and illegal instructions.
- Illegal instructions never assert the store strobe.
- The store strobe only ever accompanies a word-store encoding.

Register contents, immediate assembly, branch decisions, link values and the cleared JALR bit are only visible through the bench's program. That program stores each computed value to memory, and a scoreboard compares every store address and data word in order against values the bench worked out by hand. The same comparison catches any store from a skipped path or from an illegal encoding.

// File: rtl/rvl_pkg.sv
package rvl_pkg;
  localparam logic [6:0] OPC_REG    = 7'b0110011;
  localparam logic [6:0] OPC_IMM    = 7'b0010011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR} alu_op_e;
  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_LINK} wb_sel_e;

  typedef struct packed {
    logic    reg_we;
    logic    mem_we;
    logic    src_imm;
    logic    is_branch;
    logic    branch_ne;
    logic    is_jal;
    logic    is_jalr;
    logic    illegal;
    alu_op_e alu_op;
    wb_sel_e wb_sel;
  } ctrl_t;
endpackage

// File: rtl/rvl_alu.sv
module rvl_alu
  import rvl_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_op_e         op,
  output logic [XLEN-1:0] y
);
  always_comb begin
    case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/rvl_regfile.sv
module rvl_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic [AW-1:0]   raddr_a,
  input  logic [AW-1:0]   raddr_b,
  output logic [XLEN-1:0] rdata_a,
  output logic [XLEN-1:0] rdata_b,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata
);
  logic [XLEN-1:0] regs [1:NREG-1];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) regs[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
endmodule

// File: rtl/rvl_decode.sv
module rvl_decode
  import rvl_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]     instr,
  output ctrl_t           ctrl,
  output logic [XLEN-1:0] imm
);
  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;
  logic [XLEN-1:0] imm_i, imm_s, imm_b, imm_j;
  logic legal;

  assign opc = instr[6:0];
  assign f3  = instr[14:12];
  assign f7  = instr[31:25];

  assign imm_i = {{(XLEN-12){instr[31]}}, instr[31:20]};
  assign imm_s = {{(XLEN-12){instr[31]}}, instr[31:25], instr[11:7]};
  assign imm_b = {{(XLEN-13){instr[31]}}, instr[31], instr[7], instr[30:25],
                  instr[11:8], 1'b0};
  assign imm_j = {{(XLEN-21){instr[31]}}, instr[31], instr[19:12], instr[20],
                  instr[30:21], 1'b0};

  always_comb begin
    ctrl  = '0;
    imm   = '0;
    legal = 1'b0;
    case (opc)
      OPC_REG: begin
        if ((f7 == 7'b0000000 && (f3 == 3'b000 || f3 == 3'b110 || f3 == 3'b111)) ||
            (f7 == 7'b0100000 && f3 == 3'b000)) begin
          legal       = 1'b1;
          ctrl.reg_we = 1'b1;
          if (f3 == 3'b111)      ctrl.alu_op = ALU_AND;
          else if (f3 == 3'b110) ctrl.alu_op = ALU_OR;
          else if (f7[5])        ctrl.alu_op = ALU_SUB;
          else                   ctrl.alu_op = ALU_ADD;
        end
      end
      OPC_IMM: if (f3 == 3'b000) begin
        legal = 1'b1; ctrl.reg_we = 1'b1; ctrl.src_imm = 1'b1; imm = imm_i;
      end
      OPC_LOAD: if (f3 == 3'b010) begin
        legal = 1'b1; ctrl.reg_we = 1'b1; ctrl.src_imm = 1'b1;
        ctrl.wb_sel = WB_MEM; imm = imm_i;
      end
      OPC_STORE: if (f3 == 3'b010) begin
        legal = 1'b1; ctrl.mem_we = 1'b1; ctrl.src_imm = 1'b1; imm = imm_s;
      end
      OPC_BRANCH: if (f3[2:1] == 2'b00) begin
        legal = 1'b1; ctrl.is_branch = 1'b1; ctrl.branch_ne = f3[0]; imm = imm_b;
      end
      OPC_JAL: begin
        legal = 1'b1; ctrl.is_jal = 1'b1; ctrl.reg_we = 1'b1;
        ctrl.wb_sel = WB_LINK; imm = imm_j;
      end
      OPC_JALR: if (f3 == 3'b000) begin
        legal = 1'b1; ctrl.is_jalr = 1'b1; ctrl.reg_we = 1'b1; ctrl.src_imm = 1'b1;
        ctrl.wb_sel = WB_LINK; imm = imm_i;
      end
      default: legal = 1'b0;
    endcase
    if (!legal) begin
      ctrl         = '0;
      ctrl.illegal = 1'b1;
      imm          = '0;
    end
  end
endmodule

// File: rtl/rvl_core.sv
module rvl_core
  import rvl_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          NREG     = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata,
  output logic        illegal
);
  localparam int AW = $clog2(NREG);

  logic [XLEN-1:0] pc, pc_seq, pc_rel, pc_next;
  logic [XLEN-1:0] imm, src_a, src_b, alu_b, alu_y, wb_data;
  logic            taken;
  ctrl_t           ctrl;

  rvl_decode #(.XLEN(XLEN)) u_dec (
    .instr (imem_rdata),
    .ctrl  (ctrl),
    .imm   (imm)
  );

  rvl_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk     (clk),
    .raddr_a (imem_rdata[15+:AW]),
    .raddr_b (imem_rdata[20+:AW]),
    .rdata_a (src_a),
    .rdata_b (src_b),
    .we      (ctrl.reg_we),
    .waddr   (imem_rdata[7+:AW]),
    .wdata   (wb_data)
  );

  assign alu_b = ctrl.src_imm ? imm : src_b;

  rvl_alu #(.XLEN(XLEN)) u_alu (
    .a  (src_a),
    .b  (alu_b),
    .op (ctrl.alu_op),
    .y  (alu_y)
  );

  assign pc_seq = pc + XLEN'(4);
  assign pc_rel = pc + imm;
  assign taken  = ctrl.is_branch & ((src_a == src_b) ^ ctrl.branch_ne);

  always_comb begin
    if (ctrl.is_jalr)               pc_next = {alu_y[XLEN-1:1], 1'b0};
    else if (ctrl.is_jal || taken)  pc_next = pc_rel;
    else                            pc_next = pc_seq;
  end

  always_comb begin
    case (ctrl.wb_sel)
      WB_MEM:  wb_data = dmem_rdata;
      WB_LINK: wb_data = pc_seq;
      default: wb_data = alu_y;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= RESET_PC;
    else     pc <= pc_next;
  end

  assign imem_addr  = pc;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = src_b;
  assign dmem_we    = ctrl.mem_we;
  assign illegal    = ctrl.illegal;
endmodule

// File: rtl/rvl_core_chk.sv
module rvl_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] imem_addr,
  input logic [31:0] imem_rdata,
  input logic        dmem_we,
  input logic        illegal
);
  logic flow_op;
  assign flow_op = (imem_rdata[6:0] == 7'b1100011) || (imem_rdata[6:0] == 7'b1101111) ||
                   (imem_rdata[6:0] == 7'b1100111);

  // R1
  reset_pc_chk: assert property (@(posedge clk) rst |=> (imem_addr == 32'h0));

  // R2
  seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (!illegal && !flow_op) |=> (imem_addr == $past(imem_addr) + 32'd4));

  // R11
  illegal_no_store_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !dmem_we);

  // R11
  illegal_pc_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |=> (imem_addr == $past(imem_addr) + 32'd4));

  // R6
  store_enc_chk: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> (imem_rdata[6:0] == 7'b0100011 && imem_rdata[14:12] == 3'b010));
endmodule

bind rvl_core rvl_core_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .imem_addr  (imem_addr),
  .imem_rdata (imem_rdata),
  .dmem_we    (dmem_we),
  .illegal    (illegal)
);

// File: tb/rvl_core_tb.sv
module rvl_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, illegal;

  logic [31:0] imem [0:63];
  logic [31:0] dmem [0:63];

  typedef struct {
    logic [31:0] a;
    logic [31:0] d;
    string       tag;
  } store_t;
  store_t sb_q[$];

  int n_checks = 0;
  int n_fail   = 0;
  int n_illegal = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rvl_core u_dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata), .illegal(illegal)
  );

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  function automatic logic [31:0] e_r(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1,
                                      logic [2:0] f3, logic [4:0] rd);
    return {f7, rs2, rs1, f3, rd, 7'b0110011};
  endfunction
  function automatic logic [31:0] e_i(logic [11:0] im, logic [4:0] rs1, logic [2:0] f3,
                                      logic [4:0] rd, logic [6:0] op);
    return {im, rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] e_s(logic [11:0] im, logic [4:0] rs2, logic [4:0] rs1,
                                      logic [2:0] f3);
    return {im[11:5], rs2, rs1, f3, im[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] e_b(logic [12:0] im, logic [4:0] rs2, logic [4:0] rs1,
                                      logic [2:0] f3);
    return {im[12], im[10:5], rs2, rs1, f3, im[4:1], im[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] e_j(logic [20:0] im, logic [4:0] rd);
    return {im[20], im[10:1], im[11], im[19:12], rd, 7'b1101111};
  endfunction
  function automatic logic [31:0] addi(logic [4:0] rd, logic [4:0] rs1, logic [11:0] im);
    return e_i(im, rs1, 3'b000, rd, 7'b0010011);
  endfunction
  function automatic logic [31:0] sw(logic [4:0] rs2, logic [4:0] rs1, logic [11:0] im);
    return e_s(im, rs2, rs1, 3'b010);
  endfunction

  task automatic expect_store(logic [31:0] a, logic [31:0] d, string tag);
    sb_q.push_back('{a: a, d: d, tag: tag});
  endtask

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // monitor: pops expected stores and watches the illegal flag
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (illegal) n_illegal++;
      if (imem_addr == 32'd168 || imem_addr == 32'd172)
        check(illegal === 1'b1 && dmem_we === 1'b0, "R11 illegal flag, no store",
              {30'd0, illegal, dmem_we}, 32'h2);
      if (dmem_we === 1'b1) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R6 unexpected store addr", dmem_addr, 32'hFFFFFFFF);
        end else begin
          store_t e;
          e = sb_q.pop_front();
          check(dmem_addr === e.a && dmem_wdata === e.d, {e.tag, " store addr"},
                dmem_addr, e.a);
          if (dmem_wdata !== e.d) $display("     %s data actual=%08h expected=%08h",
                                           e.tag, dmem_wdata, e.d);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin imem[i] = 32'h0; dmem[i] = 32'h0; end
    imem[0]  = 32'h00500093;                        // ADDI x1,x0,5
    imem[1]  = addi(2, 0, -12'sd3);
    imem[2]  = addi(7, 0, 12'h06C);
    imem[3]  = addi(8, 0, 12'h035);
    imem[4]  = e_r(7'h00, 2, 1, 3'b000, 3);         // ADD
    imem[5]  = e_r(7'h20, 2, 1, 3'b000, 4);         // SUB
    imem[6]  = e_r(7'h00, 8, 7, 3'b111, 5);         // AND
    imem[7]  = e_r(7'h00, 8, 7, 3'b110, 6);         // OR
    imem[8]  = sw(1, 0, 0);
    imem[9]  = sw(2, 0, 4);
    imem[10] = sw(3, 0, 8);
    imem[11] = sw(4, 0, 12);
    imem[12] = sw(5, 0, 16);
    imem[13] = sw(6, 0, 20);
    imem[14] = addi(12, 0, 12);
    imem[15] = e_i(-12'sd8, 12, 3'b010, 9, 7'b0000011); // LW x9,-8(x12)
    imem[16] = sw(9, 0, 24);
    imem[17] = sw(1, 12, -12'sd4);
    imem[18] = addi(0, 0, 7);
    imem[19] = sw(0, 0, 28);
    imem[20] = e_b(13'd8, 2, 1, 3'b000);            // BEQ not taken
    imem[21] = sw(1, 0, 32);
    imem[22] = e_b(13'd8, 2, 1, 3'b001);            // BNE taken
    imem[23] = sw(2, 0, 32);
    imem[24] = e_b(13'd12, 7, 7, 3'b000);           // BEQ taken
    imem[25] = sw(2, 0, 36);
    imem[26] = sw(2, 0, 36);
    imem[27] = e_b(13'd8, 1, 1, 3'b001);            // BNE not taken
    imem[28] = sw(8, 0, 36);
    imem[29] = e_j(21'd12, 13);                     // JAL x13,+12
    imem[30] = sw(2, 0, 40);
    imem[31] = sw(2, 0, 40);
    imem[32] = sw(13, 0, 40);
    imem[33] = addi(14, 0, 148);
    imem[34] = e_i(12'd5, 14, 3'b000, 14, 7'b1100111); // JALR x14,5(x14)
    imem[35] = sw(2, 0, 44);
    imem[36] = sw(2, 0, 44);
    imem[37] = sw(2, 0, 44);
    imem[38] = sw(14, 0, 44);
    imem[39] = e_j(21'd8, 15);                      // JAL x15,+8
    imem[40] = sw(2, 0, 48);
    imem[41] = sw(15, 0, 48);
    imem[42] = e_r(7'h00, 1, 1, 3'b100, 1);         // illegal funct3
    imem[43] = e_s(12'd52, 2, 0, 3'b000);           // illegal byte store
    imem[44] = sw(1, 0, 52);
    imem[45] = addi(16, 0, 3);
    imem[46] = addi(17, 0, 0);
    imem[47] = addi(17, 17, 2);
    imem[48] = addi(16, 16, -12'sd1);
    imem[49] = e_b(-13'sd8, 0, 16, 3'b001);         // BNE backward
    imem[50] = sw(17, 0, 56);
    imem[51] = e_j(21'd0, 0);                       // JAL x0,0 halt

    expect_store(32'h00, 32'd5,        "R3 ADDI 0x00500093");
    expect_store(32'h04, 32'hFFFFFFFD, "R3 ADDI negative imm");
    expect_store(32'h08, 32'd2,        "R4 ADD");
    expect_store(32'h0C, 32'd8,        "R4 SUB");
    expect_store(32'h10, 32'h24,       "R4 AND");
    expect_store(32'h14, 32'h7D,       "R4 OR");
    expect_store(32'h18, 32'hFFFFFFFD, "R5 LW negative offset");
    expect_store(32'h08, 32'd5,        "R6 SW base and negative imm");
    expect_store(32'h1C, 32'd0,        "R10 x0 write discarded");
    expect_store(32'h20, 32'd5,        "R7 BEQ not taken");
    expect_store(32'h24, 32'h35,       "R7 BEQ taken, BNE not taken");
    expect_store(32'h28, 32'd120,      "R8 JAL link");
    expect_store(32'h2C, 32'd140,      "R9 JALR rd==rs1 link");
    expect_store(32'h30, 32'd160,      "R9 JALR target bit0 cleared");
    expect_store(32'h34, 32'd5,        "R11 illegal leaves x1");
    expect_store(32'h38, 32'd6,        "R7 backward loop count");

    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(imem_addr === 32'h0 && illegal === 1'b0, "R1 reset PC", imem_addr, 32'h0);
    rst = 1'b0;
    while (imem_addr !== 32'd204) @(negedge clk);
    repeat (4) @(negedge clk);
    done = 1'b1;
    check(imem_addr === 32'd204, "R8 JAL x0 self loop", imem_addr, 32'd204);
    check(sb_q.size() == 0, "R2 all stores seen", sb_q.size(), 32'd0);
    check(n_illegal == 2, "R11 illegal cycle count", n_illegal, 32'd2);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R2 actual=%08h expected=%08h", imem_addr, 32'd204);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule